// File: doc/BRIEF.md
# SMI Generation Control Unit

This block gathers error event pulses from several uncore sources and decides, cycle by cycle, whether a system management interrupt (SMI) request must be raised. There are four source kinds. The first is a link clock/data failover. The second is a misaligned access or lock timeout. The third is a machine-check event. The fourth is a 32-bit vector of uncore errors, each gated by its own bit in an error-enable vector.

A 32-bit control word sets the policy. It holds per-source masks, a global mask over the uncore error group, a machine-check SMI enable and a 20-bit threshold. The global mask also overrides the machine-check enable and the misaligned-access mask. It never blocks the SMI-timeout error, which is bit 6 of the error vector. Machine-check SMIs are not raised at once. Each one first waits out a hardware countdown loaded from the threshold.

Software writes the control word through a simple write port and reads it back through a read port. While the lock input is high, writes have no effect. All requests are merged into a single registered pulse output.

Top module: `smi_gen_ctrl`

## Requirements
- R1: After reset the control word reads 0x0400_0000: the misaligned/lock-timeout mask (bit 26) is 1 and every other field is 0. The SMI output is 0.
- R2: Bits 31:28 and 23:20 of the control word ignore writes and always read 0. Bits 27, 26, 25, 24 and 19:0 store the written value.
- R3: While the lock input is 1, a write leaves the control word unchanged. Reads still return the current value.
- R4: A link failover event raises an SMI only when bit 27 is 0 and the link SMI enable input is 1.
- R5: A misaligned/lock-timeout event raises an SMI only when bit 26 is 0 and the global mask (bit 25) is 0.
- R6: An uncore error event at index i raises an SMI only when bit i of the error-enable input is 1. While bit 25 is 1, only index 6 (SMI timeout) can still raise one.
- R7: When bit 24 is 0 or bit 25 is 1, a machine-check event raises no SMI.
- R8: With bit 24 = 1 and bit 25 = 0, a machine-check event sampled at clock edge k loads the countdown with threshold T. The countdown decrements once per clock, and the SMI output is high after edge k+T+1. A threshold of 0 therefore raises it on the cycle after the event.
- R9: Machine-check events that arrive while a countdown is running are ignored and produce no extra SMI.
- R10: Setting bit 25 or clearing bit 24 during a countdown aborts it, and no SMI follows.
- R11: A source request sampled at edge k makes the SMI output high for the cycle after edge k. Requests from several sources in the same cycle produce one such cycle, not several.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| cfg_lock | input | 1 | Blocks writes while 1 |
| cfg_rdata | output | 32 | Current control word |
| link_fail_evt | input | 1 | Link clock/data failover event pulse |
| link_smi_en | input | 1 | Separate link-error SMI enable |
| misalign_evt | input | 1 | Misaligned access / lock timeout event pulse |
| mc_evt | input | 1 | Machine-check event pulse |
| unc_err_evt | input | 32 | Uncore error event pulses, one per error index |
| unc_err_en | input | 32 | Per-index uncore error enable |
| smi_pulse | output | 1 | SMI request pulse |

## Verification
Some rules are checked on every cycle. Reserved bits must read zero. A locked cycle must leave the control word unchanged. An output pulse must match a request in the previous cycle, and no pulse may appear without one. A countdown must abort once the global mask is set, and a finished countdown must reach the output on the next cycle. Other behaviour needs the directed scenarios. These cover the exact delay for a chosen threshold, including zero, and the way each mask combines with its enable inputs. They also cover the exemption of the SMI-timeout index from the global mask, retriggers ignored during a countdown, and same-cycle requests merging into one pulse.

// File: rtl/smi_gen_pkg.sv
package smi_gen_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned BIT_LINK_M = 27;
  localparam int unsigned BIT_MIS_M  = 26;
  localparam int unsigned BIT_GLOB_M = 25;
  localparam int unsigned BIT_MC_EN  = 24;
  localparam logic [WORD_W-1:0] WRITABLE_MASK = 32'h0F0F_FFFF;
  localparam logic [WORD_W-1:0] RESET_WORD    = 32'h0400_0000;

  function automatic logic [WORD_W-1:0] merge_write(input logic [WORD_W-1:0] wdata);
    return wdata & WRITABLE_MASK;
  endfunction

  // Uncore group: per-index enable, global mask leaves only the timeout index.
  function automatic logic unc_request(input logic [WORD_W-1:0] evt,
                                       input logic [WORD_W-1:0] en,
                                       input logic              glob_mask,
                                       input int unsigned       keep_idx);
    logic [WORD_W-1:0] allow;
    allow = glob_mask ? (WORD_W'(1) << keep_idx) : '1;
    return |(evt & en & allow);
  endfunction
endpackage

// File: rtl/smi_cfg_reg.sv
module smi_cfg_reg
  import smi_gen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  input  logic              lock,
  output logic [WORD_W-1:0] word
);
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               word_q <= RESET_WORD;
    else if (wr_en && !lock)  word_q <= merge_write(wdata);
  end

  assign word = word_q;
endmodule

// File: rtl/smi_mc_timer.sv
module smi_mc_timer #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_ok,
  input  logic             evt,
  input  logic [CNT_W-1:0] thresh,
  output logic             busy,
  output logic             fire
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  assign fire = busy_q && arm_ok && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (evt && arm_ok) begin
        busy_q <= 1'b1;
        cnt_q  <= thresh;
      end
    end else if (!arm_ok || cnt_q == '0) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = busy_q;
endmodule

// File: rtl/smi_gen_ctrl.sv
module smi_gen_ctrl
  import smi_gen_pkg::*;
#(
  parameter int unsigned THR_W     = 20,
  parameter int unsigned TIMEOUT_IX = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              cfg_lock,
  output logic [WORD_W-1:0] cfg_rdata,
  input  logic              link_fail_evt,
  input  logic              link_smi_en,
  input  logic              misalign_evt,
  input  logic              mc_evt,
  input  logic [WORD_W-1:0] unc_err_evt,
  input  logic [WORD_W-1:0] unc_err_en,
  output logic              smi_pulse
);
  logic [WORD_W-1:0] cfg_word;
  logic              glob_mask;
  logic              mc_arm_ok;
  logic              link_req;
  logic              mis_req;
  logic              unc_req;
  logic              mc_busy;
  logic              mc_fire;
  logic              any_req;
  logic              pulse_q;

  smi_cfg_reg u_cfg (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (cfg_wr_en),
    .wdata (cfg_wdata),
    .lock  (cfg_lock),
    .word  (cfg_word)
  );

  assign glob_mask = cfg_word[BIT_GLOB_M];
  assign mc_arm_ok = cfg_word[BIT_MC_EN] && !glob_mask;

  smi_mc_timer #(.CNT_W(THR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm_ok (mc_arm_ok),
    .evt    (mc_evt),
    .thresh (cfg_word[THR_W-1:0]),
    .busy   (mc_busy),
    .fire   (mc_fire)
  );

  assign link_req = link_fail_evt && link_smi_en && !cfg_word[BIT_LINK_M];
  assign mis_req  = misalign_evt && !cfg_word[BIT_MIS_M] && !glob_mask;
  assign unc_req  = unc_request(unc_err_evt, unc_err_en, glob_mask, TIMEOUT_IX);
  assign any_req  = link_req || mis_req || unc_req || mc_fire;

  always_ff @(posedge clk) begin
    if (!rst_n) pulse_q <= 1'b0;
    else        pulse_q <= any_req;
  end

  assign smi_pulse = pulse_q;
  assign cfg_rdata = cfg_word;
endmodule

// File: rtl/smi_gen_ctrl_chk.sv
module smi_gen_ctrl_chk
  import smi_gen_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_lock,
  input logic [WORD_W-1:0] cfg_rdata,
  input logic              any_req,
  input logic              mc_busy,
  input logic              mc_fire,
  input logic              smi_pulse
);
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rdata & ~WRITABLE_MASK) == '0);

  a_r3_lock_holds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_lock |=> $stable(cfg_rdata));

  a_r11_pulse_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    any_req |=> smi_pulse);

  a_r11_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> !smi_pulse);

  a_r8_fire_reaches_out: assert property (@(posedge clk) disable iff (!rst_n)
    mc_fire |=> smi_pulse);

  a_r10_abort_on_glob: assert property (@(posedge clk) disable iff (!rst_n)
    (mc_busy && cfg_rdata[BIT_GLOB_M]) |=> !mc_busy);

  a_r7_no_fire_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rdata[BIT_MC_EN] |-> !mc_fire);
endmodule

bind smi_gen_ctrl smi_gen_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_lock  (cfg_lock),
  .cfg_rdata (cfg_rdata),
  .any_req   (any_req),
  .mc_busy   (mc_busy),
  .mc_fire   (mc_fire),
  .smi_pulse (smi_pulse)
);

// File: tb/smi_gen_ctrl_tb.sv
module smi_gen_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_lock = 1'b0;
  logic [31:0] cfg_rdata;
  logic        link_fail_evt = 1'b0;
  logic        link_smi_en = 1'b0;
  logic        misalign_evt = 1'b0;
  logic        mc_evt = 1'b0;
  logic [31:0] unc_err_evt = '0;
  logic [31:0] unc_err_en = '0;
  logic        smi_pulse;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_gen_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_lock(cfg_lock), .cfg_rdata(cfg_rdata), .link_fail_evt(link_fail_evt),
    .link_smi_en(link_smi_en), .misalign_evt(misalign_evt), .mc_evt(mc_evt),
    .unc_err_evt(unc_err_evt), .unc_err_en(unc_err_en), .smi_pulse(smi_pulse)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  // Drive one-cycle stimulus already set by caller, observe over n cycles.
  // Returns pulse count and index (1-based negedge) of first pulse, 0 if none.
  task automatic observe(input int n, output int cnt, output int first);
    cnt = 0; first = 0;
    for (int i = 1; i <= n; i++) begin
      @(negedge clk);
      if (i == 1) begin
        link_fail_evt = 0; misalign_evt = 0; mc_evt = 0; unc_err_evt = '0;
      end
      if (smi_pulse) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 reset word", cfg_rdata, 32'h0400_0000);
    check("R1 reset smi", {31'b0, smi_pulse}, 32'h0);
  endtask

  task automatic t_reserved();
    wr(32'hFFFF_FFFF);
    check("R2 reserved bits", cfg_rdata, 32'h0F0F_FFFF);
    wr(32'h0000_0000);
    check("R2 clear", cfg_rdata, 32'h0);
  endtask

  task automatic t_lock();
    cfg_lock = 1'b1;
    wr(32'h0800_1234);
    check("R3 locked write", cfg_rdata, 32'h0);
    cfg_lock = 1'b0;
    wr(32'h0000_0055);
    check("R3 unlocked write", cfg_rdata, 32'h0000_0055);
  endtask

  task automatic t_link();
    int c, f;
    wr(32'h0);
    link_smi_en = 1; @(negedge clk); link_fail_evt = 1;
    observe(3, c, f); check("R4 link enabled", c, 1);
    link_smi_en = 0; @(negedge clk); link_fail_evt = 1;
    observe(3, c, f); check("R4 link en input low", c, 0);
    link_smi_en = 1; wr(32'h0800_0000); link_fail_evt = 1;
    observe(3, c, f); check("R4 link masked", c, 0);
    wr(32'h0200_0000); link_fail_evt = 1;
    observe(3, c, f); check("R4 link unaffected by global", c, 1);
    link_smi_en = 0;
  endtask

  task automatic t_misalign();
    int c, f;
    wr(32'h0400_0000); misalign_evt = 1;
    observe(3, c, f); check("R5 misalign masked", c, 0);
    wr(32'h0); misalign_evt = 1;
    observe(3, c, f); check("R5 misalign unmasked", c, 1);
    wr(32'h0200_0000); misalign_evt = 1;
    observe(3, c, f); check("R5 global overrides", c, 0);
  endtask

  task automatic t_uncore();
    int c, f;
    wr(32'h0);
    unc_err_en = 32'h0000_0048;
    @(negedge clk); unc_err_evt = 32'h0000_0008;
    observe(3, c, f); check("R6 enabled idx3", c, 1);
    @(negedge clk); unc_err_evt = 32'h0000_0010;
    observe(3, c, f); check("R6 disabled idx4", c, 0);
    wr(32'h0200_0000); unc_err_evt = 32'h0000_0008;
    observe(3, c, f); check("R6 global blocks idx3", c, 0);
    @(negedge clk); unc_err_evt = 32'h0000_0040;
    observe(3, c, f); check("R6 timeout idx6 spared", c, 1);
    unc_err_en = '0; @(negedge clk); unc_err_evt = 32'h0000_0040;
    observe(3, c, f); check("R6 timeout needs enable", c, 0);
  endtask

  task automatic t_mc_off();
    int c, f;
    wr(32'h0000_0000); mc_evt = 1;
    observe(6, c, f); check("R7 mc disabled", c, 0);
    wr(32'h0300_0000); mc_evt = 1;
    observe(6, c, f); check("R7 mc global override", c, 0);
  endtask

  task automatic t_mc_delay(input int thr);
    int c, f;
    wr(32'h0100_0000 | thr); mc_evt = 1;
    observe(thr + 6, c, f);
    check($sformatf("R8 mc delay thr=%0d", thr), f, thr + 2);
    check($sformatf("R8 mc count thr=%0d", thr), c, 1);
  endtask

  task automatic t_mc_retrig();
    int c, f;
    wr(32'h0100_0005); mc_evt = 1;
    @(negedge clk); mc_evt = 0;
    @(negedge clk); mc_evt = 1;
    observe(14, c, f);
    check("R9 retrigger count", c, 1);
    check("R9 retrigger timing", f, 5);
  endtask

  task automatic t_mc_abort();
    int c, f;
    wr(32'h0100_000A); mc_evt = 1;
    observe(3, c, f);
    wr(32'h0300_000A);
    observe(16, c, f); check("R10 abort by global", c, 0);
    wr(32'h0100_000A); mc_evt = 1;
    observe(3, c, f);
    wr(32'h0000_000A);
    wr(32'h0100_000A);
    observe(16, c, f); check("R10 abort by disable", c, 0);
  endtask

  task automatic t_merge();
    int c, f;
    wr(32'h0);
    link_smi_en = 1; unc_err_en = 32'h1;
    @(negedge clk);
    link_fail_evt = 1; misalign_evt = 1; unc_err_evt = 32'h1;
    observe(4, c, f);
    check("R11 merged count", c, 1);
    check("R11 merged timing", f, 1);
    link_smi_en = 0; unc_err_en = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_reserved();
    t_lock();
    t_link();
    t_misalign();
    t_uncore();
    t_mc_off();
    t_mc_delay(0);
    t_mc_delay(1);
    t_mc_delay(7);
    t_mc_retrig();
    t_mc_abort();
    t_merge();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end
endmodule